// File: doc/BRIEF.md
# Linear Sensor Readout Timing Controller

This controller sits on the host side of a 128-element linear photodiode array. It derives the array's clock from the system clock and issues the start pulse that freezes one exposure and begins shifting it out. While each pixel's voltage is on the analog output, it gives a one-cycle strobe to an external converter and reports that pixel's index. All timing is counted in system clock cycles. The sensor half-period is programmable and is clamped to a legal range. The charge-transfer wait and the maximum start-to-start spacing are parameters.

A requested exposure sets the spacing between frames: the spacing equals the exposure plus 18 sensor clock periods. That spacing is held between a hardware minimum (129 clock periods plus the transfer wait) and a hardware maximum. When the request is below the minimum, a sticky error flag is set and the longer wait is used. In continuous mode frames follow one another at that spacing. In single mode a frame starts on a start request, once the spacing rules allow it. After reset, one flush frame runs on its own to clear out indeterminate charge. That frame produces neither strobes nor a done pulse. Divider and exposure are sampled only when a frame is launched.

Top module: `linscan_timer`

## Requirements
- R1: During and after reset, `sclk_o`, `si_o`, `strobe_o`, `done_o` and `err_o` are 0, and `sclk_o` stays 0 whenever no frame is running.
- R2: The first frame after reset starts without any request. It issues a full PIXELS+1 clocks, gives no `strobe_o` and no `done_o`, and does not set `err_o`.
- R3: `si_o` rises while `sclk_o` is low, H system cycles before the first rising edge of the frame. It falls together with the first falling edge, so exactly one rising edge sees it high.
- R4: The sensor clock half-period H equals `half_div_i`, clamped to [HALF_MIN, HALF_MAX] system cycles. Each frame has exactly PIXELS+1 rising edges, every high and low phase lasts at least HALF_MIN cycles, and the clock rests low between frames.
- R5: At the falling edge of each of clocks 1 to PIXELS, `strobe_o` pulses for one cycle. `pix_o` gives the pixel index 0 to PIXELS-1, in that order. No strobe is given on clock PIXELS+1.
- R6: `done_o` pulses for one cycle at the falling edge of clock PIXELS+1 of each non-flush frame.
- R7: The next `si_o` rise comes at least XFER_CYC cycles after the last falling edge of the previous frame. The spacing between first rising edges is never below (2*PIXELS+2)*H + XFER_CYC, using the earlier frame's H.
- R8: When the exposure request lies within the limits, the spacing between the first rising edges of consecutive continuous-mode frames is exactly `expo_i` + 2*RESET_CLKS*H.
- R9: A requested spacing above SPACE_MAX is clamped to SPACE_MAX.
- R10: `err_o` is set when a non-flush frame is launched with a requested spacing below the minimum, and it stays set until reset. The frame then uses the minimum spacing.
- R11: A change of `half_div_i` or `expo_i` during a frame does not affect that frame. The values are sampled on the cycle a frame is launched.
- R12: With `cont_i` low, no frame starts without a `start_i` pulse. A pulse that arrives too early is held until the spacing rules allow a launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div_i | input | DIV_W | Requested sensor clock half-period in system cycles |
| expo_i | input | EXP_W | Requested exposure in system cycles |
| cont_i | input | 1 | 1: continuous frames, 0: single frames on request |
| start_i | input | 1 | One-cycle frame request in single mode |
| sclk_o | output | 1 | Sensor clock |
| si_o | output | 1 | Sensor start pulse |
| strobe_o | output | 1 | Converter sample strobe, one cycle per pixel |
| pix_o | output | $clog2(PIXELS) | Index of the strobed pixel |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| err_o | output | 1 | Sticky flag: a requested spacing was too short |

## Verification
The bound checker watches several properties on every cycle:
- the start pulse rises only while the sensor clock is low, and is low after each falling edge;
- strobes and done pulses fall only on falling clock edges and never coincide;
- every clock phase lasts at least the minimum half-period;
- the error flag never clears.

Other behaviours depend on counts taken over a whole frame or between frames, so only the bench scenarios can show them:
- the exact spacing between frames for in-range, clamped and too-short exposures;
- the wait after the last clock when the half-period grows;
- the absence of strobes in the flush frame;
- divider changes in the middle of a frame that have no effect;
- the absence of a launch without a request in single mode.

// File: rtl/linscan_timer.sv
module linscan_timer #(
  parameter int PIXELS     = 128,
  parameter int RESET_CLKS = 18,
  parameter int HALF_MIN   = 3,
  parameter int HALF_MAX   = 5000,
  parameter int XFER_CYC   = 1000,
  parameter int SPACE_MAX  = 5_000_000,
  parameter int DIV_W      = 16,
  parameter int EXP_W      = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DIV_W-1:0]          half_div_i,
  input  logic [EXP_W-1:0]          expo_i,
  input  logic                      cont_i,
  input  logic                      start_i,
  output logic                      sclk_o,
  output logic                      si_o,
  output logic                      strobe_o,
  output logic [$clog2(PIXELS)-1:0] pix_o,
  output logic                      done_o,
  output logic                      err_o
);
  localparam int LAST_EDGE = 2*PIXELS + 1;
  localparam int EW        = $clog2(LAST_EDGE + 1);
  localparam int HW        = $clog2(HALF_MAX + 1);
  localparam int PW        = $clog2(PIXELS);
  localparam int MINSP_TOP = (2*PIXELS + 2)*HALF_MAX + XFER_CYC;
  localparam int SW        = $clog2(MINSP_TOP + SPACE_MAX + 1) + 1;
  localparam int CW        = ((EXP_W > SW) ? EXP_W : SW) + HW + 8;

  logic          busy, flush_pend, flushing, start_req;
  logic [HW-1:0] h_r, ph;
  logic [EW-1:0] e;
  logic [SW-1:0] since, simin_r, sp_r;

  wire [HW-1:0] h_new = (half_div_i < DIV_W'(HALF_MIN)) ? HW'(HALF_MIN) :
                        (half_div_i > DIV_W'(HALF_MAX)) ? HW'(HALF_MAX) : HW'(half_div_i);

  wire [CW-1:0] minsp_w = CW'(h_new) * CW'(2*PIXELS + 2) + CW'(XFER_CYC);
  wire [CW-1:0] simin_w = CW'(h_new) * CW'(LAST_EDGE) + CW'(XFER_CYC);
  wire [CW-1:0] tgt_w   = CW'(expo_i) + CW'(h_new) * CW'(2*RESET_CLKS);
  wire [CW-1:0] cap_w   = (tgt_w > CW'(SPACE_MAX)) ? CW'(SPACE_MAX) : tgt_w;
  wire [CW-1:0] sp_w    = (flush_pend || cap_w < minsp_w) ? minsp_w : cap_w;
  wire          short_w = tgt_w < minsp_w;
  wire [CW-1:0] since1  = CW'(since) + CW'(1);

  wire want = cont_i || start_req || start_i;
  wire go   = !busy && (flush_pend ||
              (want && since1 >= CW'(simin_r) && since1 + CW'(h_new) >= CW'(sp_r)));
  wire tick = busy && (ph == h_r - 1'b1);
  wire last = (e == EW'(LAST_EDGE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      flush_pend <= 1'b1;
      flushing   <= 1'b0;
      start_req  <= 1'b0;
      h_r        <= HW'(HALF_MIN);
      ph         <= '0;
      e          <= '0;
      since      <= '1;
      simin_r    <= '0;
      sp_r       <= '0;
      sclk_o     <= 1'b0;
      si_o       <= 1'b0;
      strobe_o   <= 1'b0;
      pix_o      <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      strobe_o  <= 1'b0;
      done_o    <= 1'b0;
      start_req <= go ? 1'b0 : (start_req | start_i);
      since     <= (since == '1) ? since : since + 1'b1;
      if (go) begin
        busy       <= 1'b1;
        si_o       <= 1'b1;
        ph         <= '0;
        e          <= '0;
        h_r        <= h_new;
        flushing   <= flush_pend;
        flush_pend <= 1'b0;
        simin_r    <= SW'(simin_w);
        sp_r       <= SW'(sp_w);
        if (!flush_pend && short_w) err_o <= 1'b1;
      end else if (tick) begin
        ph <= '0;
        e  <= e + 1'b1;
        if (!e[0]) begin
          sclk_o <= 1'b1;
          if (e == '0) since <= '0;
        end else begin
          sclk_o <= 1'b0;
          si_o   <= 1'b0;
          if (last) begin
            busy   <= 1'b0;
            done_o <= !flushing;
          end else if (!flushing) begin
            strobe_o <= 1'b1;
            pix_o    <= PW'(e >> 1);
          end
        end
      end else if (busy) begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/linscan_timer_chk.sv
module linscan_timer_chk #(
  parameter int HALF_MIN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic sclk_o,
  input logic si_o,
  input logic strobe_o,
  input logic done_o,
  input logic err_o
);
  logic [15:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= sclk_o ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= sclk_o ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  // R3
  si_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_o) |-> !sclk_o);
  // R3
  si_low_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> !si_o);
  // R4
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> hi_cnt >= 16'(HALF_MIN));
  // R4
  low_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> lo_cnt >= 16'(HALF_MIN));
  // R5
  strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> $fell(sclk_o));
  // R6
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($fell(sclk_o) && !strobe_o));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_o) |-> err_o);
endmodule

bind linscan_timer linscan_timer_chk #(.HALF_MIN(HALF_MIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .si_o(si_o),
  .strobe_o(strobe_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/linscan_timer_tb.sv
module linscan_timer_tb_top;
  localparam int CLK_T = 10;
  localparam int PX = 128, RC = 18, HMIN = 2, HMAX = 8, XF = 20, SPM = 3000;
  localparam int DW = 16, EW = 24;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] div = 2;
  logic [EW-1:0] expo = 0;
  logic cont = 0, start = 0;
  logic sclk, si, strobe, done, err;
  logic [$clog2(PX)-1:0] pix;

  always #(CLK_T/2) clk = ~clk;

  linscan_timer #(.PIXELS(PX), .RESET_CLKS(RC), .HALF_MIN(HMIN), .HALF_MAX(HMAX),
    .XFER_CYC(XF), .SPACE_MAX(SPM), .DIV_W(DW), .EXP_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_div_i(div), .expo_i(expo), .cont_i(cont),
    .start_i(start), .sclk_o(sclk), .si_o(si), .strobe_o(strobe), .pix_o(pix),
    .done_o(done), .err_o(err));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clamp_h(input int d);
    if (d < HMIN) return HMIN;
    if (d > HMAX) return HMAX;
    return d;
  endfunction

  // reference model: frame timeline from the requirements
  longint cyc, m_S, m_t0, m_simin, m_sp, m_pix;
  int m_H;
  bit m_act, m_fpend, m_req, m_err, m_flush;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_act = 0; m_fpend = 1; m_req = 0; m_err = 0; m_flush = 0;
      m_S = -1000000; m_t0 = 64'd1 << 40; m_H = 1; m_simin = 0; m_sp = 0; m_pix = 0;
    end else begin
      if (!m_act) begin
        int hn;
        hn = clamp_h(int'(div));
        if (m_fpend || ((cont || m_req || start) && (cyc - m_S + 1 >= m_simin)
                        && (cyc - m_S + 1 + hn >= m_sp))) begin
          longint minsp, tgt;
          minsp = longint'(2*PX + 2) * hn + XF;
          tgt = longint'(expo) + 2*RC*hn;
          m_act = 1; m_t0 = cyc + 1; m_H = hn; m_S = cyc + 1 + hn; m_flush = m_fpend;
          m_simin = longint'(2*PX + 1) * hn + XF;
          if (m_fpend) m_sp = minsp;
          else begin
            if (tgt < minsp) m_err = 1;
            m_sp = (tgt > SPM) ? SPM : tgt;
            if (m_sp < minsp) m_sp = minsp;
          end
          m_fpend = 0; m_req = 0;
        end else if (start) m_req = 1;
      end else if (start) m_req = 1;
      cyc++;
      if (m_act && cyc == m_S + (2*PX + 1) * m_H) m_act = 0;
    end
  end

  // per-cycle comparison and event monitor
  longint nc = 0, last_fall = 0, gap = 0;
  longint s_q[$];
  int f_rises, f_strobes, f_dones, hirun, himin, himax;
  bit p_sclk = 0, p_si = 0;

  always @(posedge clk) if (rst_n) nc++;

  always @(negedge clk) begin
    if (rst_n) begin
      longint o;
      bit inf, e_si, e_sclk, e_str, e_done;
      o = cyc - m_S;
      inf = cyc >= m_t0;
      e_si = inf && cyc < m_S + m_H;
      e_sclk = inf && o >= 0 && o < (2*PX + 1) * m_H && ((o / m_H) % 2 == 0);
      e_str = inf && !m_flush && o >= m_H && o < (2*PX + 1) * m_H && ((o - m_H) % (2*m_H) == 0);
      e_done = inf && !m_flush && o == (2*PX + 1) * m_H;
      if (e_str) m_pix = (o - m_H) / (2*m_H);
      chk(sclk == e_sclk, "R4 sensor clock", sclk, e_sclk);
      chk(si == e_si, "R3 start pulse", si, e_si);
      chk(strobe == e_str, "R5 strobe", strobe, e_str);
      chk(longint'(pix) == m_pix, "R5 pixel index", pix, m_pix);
      chk(done == e_done, "R6 done", done, e_done);
      chk(err == m_err, "R10 error flag", err, m_err);

      if (si && !p_si) begin
        gap = nc - last_fall;
        f_rises = 0; f_strobes = 0; f_dones = 0; hirun = 0; himin = 1 << 20; himax = 0;
      end
      if (sclk && !p_sclk) begin
        f_rises++;
        if (si) s_q.push_back(nc);
      end
      if (sclk) hirun++;
      if (!sclk && p_sclk) begin
        last_fall = nc;
        if (hirun < himin) himin = hirun;
        if (hirun > himax) himax = hirun;
        hirun = 0;
      end
      if (strobe) f_strobes++;
      if (done) f_dones++;
      p_sclk = sclk; p_si = si;
    end
  end

  task automatic wait_s(input int n);
    while (s_q.size() < n) @(negedge clk);
  endtask

  task automatic wait_until(input longint t);
    while (nc < t) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!sclk && !si && !strobe && !done && !err, "R1 reset outputs", {sclk, si, strobe, done, err}, 0);
    rst_n = 1;

    // R2 flush frame
    wait_s(1);
    wait_until(s_q[0] + 257*2 + 4);
    chk(f_strobes == 0, "R2 flush strobes", f_strobes, 0);
    chk(f_dones == 0, "R2 flush done", f_dones, 0);
    chk(f_rises == PX + 1, "R4 flush clock count", f_rises, PX + 1);
    chk(err == 0, "R2 flush error", err, 0);

    // R12 no launch without request
    repeat (1000) @(negedge clk);
    chk(s_q.size() == 1, "R12 idle single mode", s_q.size(), 1);
    chk(sclk == 0, "R1 idle clock low", sclk, 0);

    // single frame, H=3, exposure 1000
    div = 3; expo = 1000; start = 1;
    @(negedge clk); start = 0;
    wait_s(2);
    chk(err == 0, "R10 no error in range", err, 0);
    wait_until(s_q[1] + 100);
    div = 5;
    wait_until(s_q[1] + 700);
    div = 3;
    wait_until(s_q[1] + 780);
    chk(f_strobes == PX, "R5 strobe count", f_strobes, PX);
    chk(f_dones == 1, "R6 done count", f_dones, 1);
    chk(f_rises == PX + 1, "R4 clock count", f_rises, PX + 1);
    chk(himin == 3 && himax == 3, "R11 mid-frame divider ignored", himax, 3);

    // continuous mode
    cont = 1;
    wait_s(3);
    chk(s_q[2] - s_q[1] == 1108, "R8 exposure spacing", s_q[2] - s_q[1], 1108);
    expo = 0;
    wait_s(4);
    chk(s_q[3] - s_q[2] == 1108, "R11 new exposure waits for boundary", s_q[3] - s_q[2], 1108);
    chk(err == 1, "R10 short request sets error", err, 1);
    div = 2; expo = 5000;
    wait_s(5);
    chk(s_q[4] - s_q[3] == 794, "R7 minimum spacing", s_q[4] - s_q[3], 794);
    div = 8; expo = 0;
    wait_s(6);
    chk(s_q[5] - s_q[4] == SPM, "R9 maximum clamp", s_q[5] - s_q[4], SPM);
    div = 2;
    wait_s(7);
    chk(s_q[6] - s_q[5] == 2084, "R10 error uses minimum", s_q[6] - s_q[5], 2084);
    chk(err == 1, "R10 error sticky", err, 1);
    div = 8;
    wait_s(8);
    chk(s_q[7] - s_q[6] == 542, "R7 spacing with growing half-period", s_q[7] - s_q[6], 542);
    chk(gap >= XF, "R7 transfer wait", gap, XF);
    cont = 0;
    repeat (5000) @(negedge clk);
    chk(s_q.size() == 8, "R12 stop when continuous low", s_q.size(), 8);
    chk(sclk == 0 && si == 0, "R1 idle low after stop", {sclk, si}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule